// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is the target side of a serial NOR flash command port. A host drives a serial clock, a select line and a data-in line. The block shifts bytes in, decodes an 8-bit opcode and answers on a data-out line. Behind the port sit a small byte array and a status register. The block handles these commands: status read, status write, write enable, plain read, read with a dummy byte, page program and sector erase. While an operation runs, the busy bit is set, and the busy time comes from a cycle counter with a separate length for each operation.

The serial pins are oversampled by the system clock. Each serial clock phase, high and low, must last at least four system clocks, and the select line must stay steady for four system clocks around the last serial edge. A write-class command changes storage only when the select line rises on a byte boundary. Program data collects in a page buffer and is merged into the array at that moment.

Controller states: IDLE waits for an opcode. ADDR collects three address bytes. DUMMY swallows one byte. READ streams array bytes. STAT streams the status byte. SRIN takes the new status byte, and SRARM then holds it until the select line rises. PROG collects program data. ERARM holds an armed erase. WEARM holds an armed write enable. DROP swallows every byte up to deselect. A byte arriving in IDLE moves the controller to STAT, WEARM, ADDR, SRIN or DROP, depending on the opcode and on the busy bit and write-enable bit. ADDR moves to READ, DUMMY, PROG or ERARM after its third byte. DUMMY moves to READ, SRIN moves to SRARM, and an extra byte in WEARM moves to DROP. A rising select line returns every state to IDLE.

Top module: `spi_flash_engine`

## Requirements
- R1: Bus modes 0 and 3 are both accepted. Data in is sampled on the rising serial clock edge, and data out changes on the falling edge. The first bit of a returned byte appears on the falling edge that follows the last rising edge of the previous byte. Data out is held low while the select line is high.
- R2: Status byte layout, from bit 7 down to bit 0: status-write lock, quad enable, four block-protect bits (bit 5 down to bit 2), write-enable latch, busy. Opcode 05h returns this byte repeatedly until deselect, and it is served even while busy. The status byte after reset is 00h.
- R3: Opcode 06h sets the write-enable latch when the select line rises just after that single byte. Any extra byte or partial byte cancels it.
- R4: Opcode 03h is followed by three address bytes, most significant first. Array bytes then stream out from that address, which increments after each byte and wraps at the end of the array (2^ADDR_W bytes).
- R5: Opcode 0Bh works like 03h, but one dummy byte is inserted between the address and the first data byte.
- R6: Opcode 02h is accepted only with the write-enable latch set. It takes 1 to 256 or more data bytes. The byte offset wraps within the 256-byte page, and a later byte at the same offset replaces an earlier one. Each stored byte becomes old AND new. A command with no data byte changes nothing.
- R7: Opcode 20h is accepted only with the write-enable latch set. After three address bytes, it sets every byte of the addressed sector (2^SECT_W bytes) to FFh.
- R8: Opcode 01h is accepted only with the write-enable latch set. It loads status bits 7 to 2 from the first data byte. It is rejected with no effect when the status-write lock is 1 and the protect pin is low.
- R9: A committed program, erase or status write holds the busy bit for PROG_CYC, ERASE_CYC or WRSR_CYC clocks. The write-enable latch clears in the same cycle that the busy bit falls.
- R10: While the busy bit is 1, every opcode other than 05h is ignored. A read returns only 00h bytes, and nothing changes.
- R11: When an accepted write-class command is ended by a select rise that falls inside a byte, the array and status fields are left unchanged. The busy bit is then held for ABORT_CYC clocks, after which the write-enable latch clears.
- R12: A rising select line at any point returns the decoder to idle. The next byte after the select line falls again is decoded as a fresh opcode.
- R13: An unknown opcode returns 00h bytes and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low protect pin for status writes |
| so | output | 1 | Serial data out |

## Verification
The bench targets the following corner cases:
- A program that runs past the end of its page. A design that did not wrap would corrupt the next page.
- A second program over data that is already programmed. A design that wrote instead of merging with AND would set bits back to 1.
- A read that crosses the top of the array.
- A status write attempted with the lock bit set and the protect pin low.
- A write command cut off partway through a byte. A design that committed it anyway would change the array or the status. A design that skipped the abort busy window would show no busy bit.
- Reads and opcodes sent while busy, with only 00h expected. A design that still accepted them would return array data or set the write-enable latch.
- Abandoned and partial commands followed by a status read. A design that kept stale decode state would misread the next opcode.

// File: rtl/spif_pkg.sv
package spif_pkg;

    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_PROG = 8'h02;
    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_FAST = 8'h0B;
    localparam logic [7:0] OPC_SERS = 8'h20;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DUMMY,
        ST_READ,
        ST_STAT,
        ST_SRIN,
        ST_SRARM,
        ST_PROG,
        ST_ERARM,
        ST_WEARM,
        ST_DROP
    } fsm_e;

endpackage

// File: rtl/spif_shifter.sv
module spif_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    input  logic [7:0] tx_byte,
    output logic       so,
    output logic [7:0] rx_byte,
    output logic       byte_stb,
    output logic       cs_rise,
    output logic       aligned
);
    logic       sck_q;
    logic       cs_q;
    logic [2:0] bit_cnt;
    logic [7:0] sh;
    logic       rise;
    logic       fall;

    assign rise    = sck & ~sck_q & ~cs_n;
    assign fall    = ~sck & sck_q & ~cs_n;
    assign cs_rise = cs_n & ~cs_q;
    assign aligned = (bit_cnt == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_byte  <= '0;
            byte_stb <= 1'b0;
            sh       <= '0;
            so       <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
                so      <= 1'b0;
            end else begin
                if (rise) begin
                    rx_byte <= {rx_byte[6:0], si};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        byte_stb <= 1'b1;
                    end
                end
                if (fall) begin
                    if (bit_cnt == 3'd0) begin
                        so <= tx_byte[7];
                        sh <= {tx_byte[6:0], 1'b0};
                    end else begin
                        so <= sh[7];
                        sh <= {sh[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spif_busy.sv
module spif_busy #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             wip,
    output logic             done
);
    logic [LEN_W-1:0] cnt;

    assign wip  = (cnt != '0);
    assign done = (cnt == LEN_W'(1)) && !start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - LEN_W'(1);
        end
    end
endmodule

// File: rtl/spif_array.sv
module spif_array #(
    parameter int ADDR_W = 10,
    parameter int SECT_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    input  logic                     buf_clr,
    input  logic                     buf_we,
    input  logic [7:0]               buf_idx,
    input  logic [7:0]               buf_wdata,
    input  logic                     prog_go,
    input  logic [ADDR_W-9:0]        prog_page,
    input  logic                     erase_go,
    input  logic [ADDR_W-SECT_W-1:0] erase_sect
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int SECT_BYTES = 1 << SECT_W;
    localparam int PAGE_BYTES = 256;

    logic [7:0] mem  [DEPTH];
    logic [7:0] pbuf [PAGE_BYTES];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
        end else if (buf_clr) begin
            for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
        end else if (buf_we) begin
            pbuf[buf_idx] <= buf_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            if (erase_go) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if ((i / SECT_BYTES) == int'(erase_sect)) mem[i] <= 8'hFF;
                end
            end
            if (prog_go) begin
                for (int j = 0; j < PAGE_BYTES; j++) begin
                    mem[{prog_page, 8'(j)}] <= mem[{prog_page, 8'(j)}] & pbuf[j];
                end
            end
        end
    end
endmodule

// File: rtl/spif_ctrl.sv
module spif_ctrl
    import spif_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int SECT_W    = 9,
    parameter int LEN_W     = 12,
    parameter int PROG_CYC  = 400,
    parameter int ERASE_CYC = 600,
    parameter int WRSR_CYC  = 300,
    parameter int ABORT_CYC = 200
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_stb,
    input  logic [7:0]               rx_byte,
    input  logic                     cs_rise,
    input  logic                     aligned,
    input  logic                     wp_n,
    input  logic                     wip,
    input  logic                     busy_done,
    input  logic [7:0]               rd_data,
    output logic [7:0]               tx_byte,
    output logic [7:0]               status,
    output logic                     wel,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     buf_clr,
    output logic                     buf_we,
    output logic [7:0]               buf_idx,
    output logic [7:0]               buf_wdata,
    output logic                     prog_go,
    output logic [ADDR_W-9:0]        prog_page,
    output logic                     erase_go,
    output logic [ADDR_W-SECT_W-1:0] erase_sect,
    output logic                     sr_go,
    output logic                     busy_start,
    output logic [LEN_W-1:0]         busy_len
);
    fsm_e        state, state_n;
    logic [7:0]  op;
    logic [ADDR_W-1:0] adr;
    logic [1:0]  acnt;
    logic [7:0]  pp_off;
    logic        pp_any;
    logic [7:0]  sr_new;
    logic        wr_cmd;
    logic        srwd, qe;
    logic [3:0]  bp;
    logic        last_addr;
    logic        abort;
    logic        commit_wren;
    logic        wr_opc;

    assign status     = {srwd, qe, bp, wel, wip};
    assign rd_addr    = adr;
    assign prog_page  = adr[ADDR_W-1:8];
    assign erase_sect = adr[ADDR_W-1:SECT_W];
    assign last_addr  = (state == ST_ADDR) && (acnt == 2'd2);
    assign wr_opc     = (rx_byte == OPC_PROG) || (rx_byte == OPC_SERS) || (rx_byte == OPC_WRSR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        if (cs_rise) begin
            state_n = ST_IDLE;
        end else if (byte_stb) begin
            unique case (state)
                ST_IDLE: begin
                    if (rx_byte == OPC_RDSR)      state_n = ST_STAT;
                    else if (wip)                 state_n = ST_DROP;
                    else if (rx_byte == OPC_WREN) state_n = ST_WEARM;
                    else if (rx_byte == OPC_READ || rx_byte == OPC_FAST) state_n = ST_ADDR;
                    else if (rx_byte == OPC_PROG || rx_byte == OPC_SERS)
                        state_n = wel ? ST_ADDR : ST_DROP;
                    else if (rx_byte == OPC_WRSR) state_n = wel ? ST_SRIN : ST_DROP;
                    else                          state_n = ST_DROP;
                end
                ST_ADDR: begin
                    if (acnt == 2'd2) begin
                        if (op == OPC_READ)      state_n = ST_READ;
                        else if (op == OPC_FAST) state_n = ST_DUMMY;
                        else if (op == OPC_PROG) state_n = ST_PROG;
                        else if (op == OPC_SERS) state_n = ST_ERARM;
                        else                     state_n = ST_DROP;
                    end
                end
                ST_DUMMY: state_n = ST_READ;
                ST_SRIN:  state_n = ST_SRARM;
                ST_WEARM: state_n = ST_DROP;
                ST_READ, ST_STAT, ST_SRARM, ST_PROG, ST_ERARM, ST_DROP: state_n = state;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_READ: tx_byte = rd_data;
            ST_STAT: tx_byte = status;
            default: tx_byte = 8'h00;
        endcase
        buf_clr     = byte_stb && last_addr && (op == OPC_PROG);
        buf_we      = byte_stb && (state == ST_PROG);
        buf_idx     = pp_off;
        buf_wdata   = rx_byte;
        commit_wren = cs_rise && aligned && (state == ST_WEARM);
        abort       = cs_rise && !aligned && wr_cmd;
        sr_go       = cs_rise && aligned && (state == ST_SRARM) && !(srwd && !wp_n);
        prog_go     = cs_rise && aligned && (state == ST_PROG) && pp_any;
        erase_go    = cs_rise && aligned && (state == ST_ERARM);
        busy_start  = abort || sr_go || prog_go || erase_go;
        if (abort)         busy_len = LEN_W'(ABORT_CYC);
        else if (prog_go)  busy_len = LEN_W'(PROG_CYC);
        else if (erase_go) busy_len = LEN_W'(ERASE_CYC);
        else               busy_len = LEN_W'(WRSR_CYC);
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op     <= '0;
            adr    <= '0;
            acnt   <= '0;
            pp_off <= '0;
            pp_any <= 1'b0;
            sr_new <= '0;
            wr_cmd <= 1'b0;
        end else if (cs_rise) begin
            wr_cmd <= 1'b0;
        end else if (byte_stb) begin
            unique case (state)
                ST_IDLE: begin
                    op     <= rx_byte;
                    acnt   <= '0;
                    pp_any <= 1'b0;
                    wr_cmd <= wr_opc && wel && !wip;
                end
                ST_ADDR: begin
                    adr  <= {adr[ADDR_W-9:0], rx_byte};
                    acnt <= acnt + 2'd1;
                    if (acnt == 2'd2) pp_off <= rx_byte;
                end
                ST_READ: adr <= adr + ADDR_W'(1);
                ST_SRIN: sr_new <= rx_byte;
                ST_PROG: begin
                    pp_off <= pp_off + 8'd1;
                    pp_any <= 1'b1;
                end
                ST_DUMMY, ST_STAT, ST_SRARM, ST_ERARM, ST_WEARM, ST_DROP: ;
                default: ;
            endcase
        end
    end

    // status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srwd <= 1'b0;
            qe   <= 1'b0;
            bp   <= '0;
            wel  <= 1'b0;
        end else begin
            if (sr_go) {srwd, qe, bp} <= sr_new[7:2];
            if (busy_done)        wel <= 1'b0;
            else if (commit_wren) wel <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine #(
    parameter int ADDR_W    = 10,
    parameter int SECT_W    = 9,
    parameter int PROG_CYC  = 400,
    parameter int ERASE_CYC = 600,
    parameter int WRSR_CYC  = 300,
    parameter int ABORT_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic wp_n,
    output logic so
);
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC ? PROG_CYC : ERASE_CYC) >
                             (WRSR_CYC > ABORT_CYC ? WRSR_CYC : ABORT_CYC) ?
                             (PROG_CYC > ERASE_CYC ? PROG_CYC : ERASE_CYC) :
                             (WRSR_CYC > ABORT_CYC ? WRSR_CYC : ABORT_CYC);
    localparam int LEN_W = $clog2(MAX_CYC + 1);

    logic [7:0]               tx_byte, rx_byte, status, rd_data, buf_idx, buf_wdata;
    logic                     byte_stb, cs_rise, aligned;
    logic                     wip, wel, busy_done, busy_start;
    logic [LEN_W-1:0]         busy_len;
    logic [ADDR_W-1:0]        rd_addr;
    logic                     buf_clr, buf_we, prog_go, erase_go, sr_go;
    logic [ADDR_W-9:0]        prog_page;
    logic [ADDR_W-SECT_W-1:0] erase_sect;

    spif_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .tx_byte(tx_byte), .so(so), .rx_byte(rx_byte), .byte_stb(byte_stb),
        .cs_rise(cs_rise), .aligned(aligned)
    );

    spif_ctrl #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .LEN_W(LEN_W), .PROG_CYC(PROG_CYC),
        .ERASE_CYC(ERASE_CYC), .WRSR_CYC(WRSR_CYC), .ABORT_CYC(ABORT_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .rx_byte(rx_byte),
        .cs_rise(cs_rise), .aligned(aligned), .wp_n(wp_n), .wip(wip),
        .busy_done(busy_done), .rd_data(rd_data), .tx_byte(tx_byte),
        .status(status), .wel(wel), .rd_addr(rd_addr), .buf_clr(buf_clr),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .prog_go(prog_go), .prog_page(prog_page), .erase_go(erase_go),
        .erase_sect(erase_sect), .sr_go(sr_go), .busy_start(busy_start),
        .busy_len(busy_len)
    );

    spif_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_wdata(buf_wdata), .prog_go(prog_go), .prog_page(prog_page),
        .erase_go(erase_go), .erase_sect(erase_sect)
    );

    spif_busy #(.LEN_W(LEN_W)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_start), .len(busy_len),
        .wip(wip), .done(busy_done)
    );
endmodule

// File: rtl/spif_checker.sv
module spif_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic so,
    input logic wip,
    input logic wel,
    input logic prog_go,
    input logic erase_go,
    input logic sr_go
);
    // R9: busy only ever starts from an enabled write
    a_r9_busy_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

    // R9: latch is clear once busy ends
    a_r9_wel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    // R10: no commit lands while busy or without the latch
    a_r10_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go || erase_go || sr_go) |-> (!wip && wel));

    // R6: at most one kind of commit per cycle
    a_r6_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_go, erase_go, sr_go}));

    // R1: output quiet while deselected
    a_r1_so_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !so);
endmodule

bind spi_flash_engine spif_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so(so), .wip(wip), .wel(wel),
    .prog_go(prog_go), .erase_go(erase_go), .sr_go(sr_go)
);

// File: tb/tb_spi_flash_engine.sv
`timescale 1ns/1ps
module tb_spi_flash_engine;
    localparam int ADDR_W = 10, SECT_W = 9;
    localparam int PROG = 400, ERASE = 600, WRSR = 300, ABRT = 200;
    localparam int DEPTH = 1 << ADDR_W, SECT = 1 << SECT_W;

    logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0, wp_n = 1;
    logic so;
    always #2 clk = ~clk;

    spi_flash_engine #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG),
        .ERASE_CYC(ERASE), .WRSR_CYC(WRSR), .ABORT_CYC(ABRT)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n), .so(so));

    int checks = 0, fails = 0;
    longint cyc = 0;
    logic cs_prev = 1;
    logic [7:0] q[$];
    logic [7:0] rxq[$];

    // behavioural reference
    logic [7:0] m [DEPTH];
    logic srwd = 0, qe = 0, mwel = 0, pend = 0;
    logic [3:0] bp = 0;
    longint busy_until = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // R1: output quiet while deselected, every clock
    always @(negedge clk) begin
        if (rst_n && cs_n && cs_prev) begin
            checks++;
            if (so !== 1'b0) begin
                fails++;
                $display("FAIL R1 so while deselected got=%b exp=0", so);
            end
        end
        cs_prev <= cs_n;
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input int len, input longint t1);
        busy_until = t1 + len + 2;
        pend = 1;
    endtask

    task automatic model(input int extra, input longint t0, input longint t1,
                         output logic [7:0] e[$]);
        int n = q.size();
        bit part = (extra != 0);
        bit busy;
        int a;
        logic [7:0] pb [256];
        e = {};
        if (pend && t0 >= busy_until) begin mwel = 0; pend = 0; end
        busy = (t0 < busy_until);
        for (int i = 0; i < n; i++) e.push_back(8'h00);
        if (n == 0) return;
        a = (n >= 4) ? (int'({q[1], q[2], q[3]}) % DEPTH) : 0;
        if (q[0] == 8'h05) begin
            for (int i = 1; i < n; i++) e[i] = {srwd, qe, bp, mwel, busy};
        end else if (!busy) begin
            case (q[0])
                8'h06: if (n == 1 && !part) mwel = 1;
                8'h03: for (int i = 4; i < n; i++) e[i] = m[(a + i - 4) % DEPTH];
                8'h0B: for (int i = 5; i < n; i++) e[i] = m[(a + i - 5) % DEPTH];
                8'h02: if (mwel) begin
                    if (part) start(ABRT, t1);
                    else if (n >= 5) begin
                        for (int j = 0; j < 256; j++) pb[j] = 8'hFF;
                        for (int i = 4; i < n; i++) pb[(int'(q[3]) + i - 4) % 256] = q[i];
                        for (int j = 0; j < 256; j++) m[(a & ~255) + j] &= pb[j];
                        start(PROG, t1);
                    end
                end
                8'h20: if (mwel) begin
                    if (part) start(ABRT, t1);
                    else if (n >= 4) begin
                        for (int i = 0; i < SECT; i++) m[(a / SECT) * SECT + i] = 8'hFF;
                        start(ERASE, t1);
                    end
                end
                8'h01: if (mwel) begin
                    if (part) start(ABRT, t1);
                    else if (n >= 2 && !(srwd && !wp_n)) begin
                        {srwd, qe, bp} = q[1][7:2];
                        start(WRSR, t1);
                    end
                end
                default: ;
            endcase
        end
    endtask

    task automatic sbit(input logic v, input bit m3, output logic cap);
        if (m3) begin
            sck = 0; si = v; wclk(4); cap = so; sck = 1; wclk(4);
        end else begin
            si = v; wclk(4); cap = so; sck = 1; wclk(4); sck = 0;
        end
    endtask

    task automatic run(input string tag, input int extra = 0, input bit m3 = 0);
        longint t0, t1;
        logic [7:0] e[$];
        logic [7:0] b;
        logic c;
        @(negedge clk);
        sck = m3; wclk(2);
        t0 = cyc; cs_n = 0; wclk(4);
        rxq = {};
        foreach (q[i]) begin
            for (int k = 7; k >= 0; k--) begin sbit(q[i][k], m3, c); b[k] = c; end
            rxq.push_back(b);
        end
        for (int k = 0; k < extra; k++) sbit(1'b1, m3, c);
        wclk(4); t1 = cyc; cs_n = 1; wclk(8); sck = 0;
        model(extra, t0, t1, e);
        for (int i = 1; i < rxq.size(); i++) begin
            checks++;
            if (rxq[i] !== e[i]) begin
                fails++;
                $display("FAIL %s byte %0d got=%h exp=%h", tag, i, rxq[i], e[i]);
            end
        end
    endtask

    task automatic cmd_a(input logic [7:0] op, input int adr, input int npad);
        q = {};
        q.push_back(op);
        q.push_back(8'(adr >> 16)); q.push_back(8'(adr >> 8)); q.push_back(8'(adr));
        for (int i = 0; i < npad; i++) q.push_back(8'h00);
    endtask

    task automatic one(input logic [7:0] op, input int npad);
        q = {};
        q.push_back(op);
        for (int i = 0; i < npad; i++) q.push_back(8'h00);
    endtask

    task automatic wren();
        one(8'h06, 0); run("R3 wren");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m[i] = 8'hFF;
        wclk(5); rst_n = 1; wclk(5);

        // reset status R2
        one(8'h05, 2); run("R2 reset status");
        // read with wrap at top of array R4
        cmd_a(8'h03, 12'h3FE, 4); run("R4 read wrap");
        // program without latch is ignored R6
        cmd_a(8'h02, 0, 0); q.push_back(8'h55); run("R6 prog no wel");
        cmd_a(8'h03, 0, 2); run("R6 no-wel readback");
        // R3 latch set, R2 layout
        wren(); one(8'h05, 1); run("R3 wel status");
        // program wrapping in page R6, busy R9, dropped read R10
        cmd_a(8'h02, 12'h0F0, 0);
        for (int k = 0; k < 20; k++) q.push_back(8'(k * 7 + 1));
        run("R6 prog wrap");
        one(8'h05, 1); run("R9 busy seen");
        cmd_a(8'h03, 12'h0F0, 2); run("R10 read while busy");
        wren();
        wclk(PROG + 50);
        one(8'h05, 1); run("R9 wel cleared");
        cmd_a(8'h03, 12'h0F0, 16); run("R6 page tail");
        cmd_a(8'h03, 12'h000, 5); run("R6 page wrap head");
        // AND merge R6
        wren(); cmd_a(8'h02, 12'h0F0, 0); q.push_back(8'hA5); q.push_back(8'h0F);
        run("R6 and merge"); wclk(PROG + 50);
        // fast read in mode 3 R5 R1
        cmd_a(8'h0B, 12'h0F0, 5); run("R5 fast mode3", 0, 1);
        // empty program is no-op R6
        wren(); cmd_a(8'h02, 0, 0); run("R6 empty prog");
        one(8'h05, 1); run("R6 empty status");
        // erase sector 0, sector 1 kept R7
        cmd_a(8'h02, 12'h210, 0); q.push_back(8'h3C); q.push_back(8'hC3);
        run("R7 prog sect1"); wclk(PROG + 50);
        wren(); cmd_a(8'h20, 12'h0F5, 0); run("R7 erase"); wclk(ERASE + 50);
        cmd_a(8'h03, 12'h0F0, 3); run("R7 erased");
        cmd_a(8'h03, 12'h210, 2); run("R7 other sector");
        // status write and protect R8
        wren(); one(8'h01, 0); q.push_back(8'hBC); run("R8 wrsr", 0, 1);
        wclk(WRSR + 50);
        one(8'h05, 1); run("R8 status after");
        wp_n = 0; wren(); one(8'h01, 0); q.push_back(8'h00); run("R8 protected");
        one(8'h05, 1); run("R8 rejected");
        wp_n = 1; one(8'h01, 0); q.push_back(8'h00); run("R8 unlocked");
        wclk(WRSR + 50); one(8'h05, 1); run("R8 cleared");
        // partial byte abort R11
        wren(); cmd_a(8'h02, 12'h040, 0); q.push_back(8'h00); q.push_back(8'h00);
        run("R11 abort", 3);
        one(8'h05, 1); run("R11 busy");
        wclk(ABRT + 50);
        one(8'h05, 1); run("R11 wel cleared");
        cmd_a(8'h03, 12'h040, 2); run("R11 untouched");
        // decoder reset R12
        q = {}; q.push_back(8'h03); q.push_back(8'h00); run("R12 abandon");
        one(8'h05, 1); run("R12 fresh");
        q = {}; run("R12 partial opcode", 5);
        one(8'h05, 2); run("R12 fresh after partial");
        // unknown opcode R13
        one(8'h9F, 3); run("R13 unknown");
        one(8'h05, 1); run("R13 status kept");
        // over-long page program R6
        wren(); cmd_a(8'h02, 12'h100, 0);
        for (int k = 0; k < 260; k++) q.push_back(8'(k * 3 + 1));
        run("R6 long prog"); wclk(PROG + 50);
        cmd_a(8'h03, 12'h100, 6); run("R6 long head");
        cmd_a(8'h03, 12'h1FC, 4); run("R6 long tail");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule